// File: doc/BRIEF.md
# Smart card activation sequencer

This block brings a contact smart card from unpowered to active in a fixed order, following ISO 7816-3 practice. A host requests activation with a falling edge on an active-low command strobe. The card supply is switched on first. At checkpoint t1 the block samples the supply-valid input. At t2 the card I/O line turns to reception mode. At t3 the card clock starts. From then on, the card reset line follows the host reset input.

The sequence aborts in three cases: the supply is not valid at t1, the card is pulled out, or a supply fault is raised. On an abort the block drops supply, clock and reset together and pulls the fault report low. A fresh falling edge of the strobe is the only way to start again.

After reset, a lockout of `LOCK_CYC` reference cycles must pass before any start is accepted. The card clock is a registered divide of the reference clock `clk_i`. The block changes the divide ratio only at the end of a card clock period, so the card never sees a runt pulse.

Top module: `sc_act_seq`

## Requirements
- R1: A falling edge of `cmd_ni` seen fewer than `LOCK_CYC` reference cycles after reset release is ignored. All outputs stay idle: `vcc_en_o`, `io_rx_o` and `card_rst_o` low, `fault_no` high.
- R2: Activation starts only on a high-to-low transition of `cmd_ni`. Holding `cmd_ni` low never restarts a sequence that has ended or aborted.
- R3: A falling edge is accepted only if `hrst_i` is low, `card_det_i` is high and `sup_fault_i` is low in that cycle. Otherwise it is ignored and the outputs stay idle.
- R4: `vcc_en_o` rises in the cycle after the accepted edge. That edge is cycle 0. At edge T1_CYC the block samples `vcc_ok_i`. If it is low, `vcc_en_o` falls and `fault_no` goes low in that same cycle.
- R5: After a good t1, `io_rx_o` rises at edge T2_CYC. `card_clk_o` stays low until edge T3_CYC and toggles from then on.
- R6: `card_rst_o` equals `hrst_i` once the card clock runs. It is low at all other times.
- R7: `div_sel_i` value k (0 to 3) gives a card clock period of 2·2^k reference cycles, with a 50% duty cycle.
- R8: A change of `div_sel_i` takes effect only after the current card clock period ends. Every high phase lasts exactly 2^k cycles for a single k.
- R9: Card removal or `sup_fault_i` at any point after start drops `vcc_en_o`, `io_rx_o`, `card_clk_o` and `card_rst_o` on the next edge and drives `fault_no` low. The next accepted start returns `fault_no` high.
- R10: During and right after reset, all outputs are low except `fault_no`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_ni | input | 1 | Host activation strobe, falling edge starts |
| hrst_i | input | 1 | Host reset request, copied to the card when active |
| card_det_i | input | 1 | Card present |
| sup_fault_i | input | 1 | Main supply fault flag |
| vcc_ok_i | input | 1 | Card supply reached its level |
| div_sel_i | input | 2 | Card clock ratio select |
| vcc_en_o | output | 1 | Card supply enable |
| io_rx_o | output | 1 | Card I/O in reception mode |
| card_clk_o | output | 1 | Divided card clock |
| card_rst_o | output | 1 | Card reset line |
| fault_no | output | 1 | Fault report to host, active low |

## Verification
The hardest case to reach is a ratio change in the middle of a high phase of the card clock. The bench selects the slowest ratio, waits for a rising edge of `card_clk_o`, and switches to the fastest ratio in the next cycle. It then measures the high phase that was already running and the one after it. A second hard case is a strobe that stays low after an abort. The bench leaves `cmd_ni` low through the abort and through the return of a good supply or card, and confirms that nothing restarts.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_IOWAIT,
    ST_CLKWAIT,
    ST_ACTIVE
  } seq_st_e;
endpackage

// File: rtl/sc_lockout.sv
module sc_lockout #(
  parameter int unsigned LOCK_CYC = 270000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q != CW'(LOCK_CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LOCK_CYC));
endmodule

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);
  localparam int unsigned HC_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] exp_q;
  logic [HC_W-1:0]  hc_q;
  logic [HC_W:0]    span;
  logic [HC_W-1:0]  lim;
  logic             clk_q;

  assign span = (HC_W+1)'(1) << exp_q;
  assign lim  = span[HC_W-1:0] - HC_W'(1);

  // ratio is latched only while stopped or when a high phase ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      hc_q  <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      exp_q <= sel_i;
      hc_q  <= '0;
      clk_q <= 1'b0;
    end else if (hc_q == lim) begin
      hc_q  <= '0;
      clk_q <= ~clk_q;
      if (clk_q) exp_q <= sel_i;
    end else begin
      hc_q  <= hc_q + 1'b1;
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_act_pkg::*;
#(
  parameter int unsigned T1_CYC = 2700,
  parameter int unsigned T2_CYC = 5400,
  parameter int unsigned T3_CYC = 8100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_done_i,
  input  logic cmd_ni,
  input  logic hrst_i,
  input  logic card_det_i,
  input  logic sup_fault_i,
  input  logic vcc_ok_i,
  output logic vcc_en_o,
  output logic io_rx_o,
  output logic active_o,
  output logic clk_run_d_o,
  output logic fault_o
);
  localparam int unsigned TW = $clog2(T3_CYC + 1);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          flt_q, flt_d;
  logic          cmd_q;
  logic          fall, start_ok, lost;

  assign fall     = cmd_q & ~cmd_ni;
  assign start_ok = fall & lock_done_i & ~hrst_i & card_det_i & ~sup_fault_i;
  assign lost     = ~card_det_i | sup_fault_i;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    flt_d  = flt_q;
    if (st_q == ST_IDLE) begin
      if (start_ok) begin
        st_d   = ST_RAMP;
        tcnt_d = TW'(1);
        flt_d  = 1'b0;
      end
    end else if (lost) begin
      st_d  = ST_IDLE;
      flt_d = 1'b1;
    end else begin
      if (st_q != ST_ACTIVE) tcnt_d = tcnt_q + 1'b1;
      unique case (st_q)
        ST_RAMP: if (tcnt_q == TW'(T1_CYC)) begin
          if (vcc_ok_i) st_d = ST_IOWAIT;
          else begin
            st_d  = ST_IDLE;
            flt_d = 1'b1;
          end
        end
        ST_IOWAIT:  if (tcnt_q == TW'(T2_CYC)) st_d = ST_CLKWAIT;
        ST_CLKWAIT: if (tcnt_q == TW'(T3_CYC)) st_d = ST_ACTIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      flt_q  <= 1'b0;
      cmd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      flt_q  <= flt_d;
      cmd_q  <= cmd_ni;
    end
  end

  assign vcc_en_o    = (st_q != ST_IDLE);
  assign io_rx_o     = (st_q == ST_CLKWAIT) || (st_q == ST_ACTIVE);
  assign active_o    = (st_q == ST_ACTIVE);
  assign clk_run_d_o = (st_d == ST_ACTIVE);
  assign fault_o     = flt_q;
endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq #(
  parameter int unsigned LOCK_CYC = 270000,
  parameter int unsigned T1_CYC   = 2700,
  parameter int unsigned T2_CYC   = 5400,
  parameter int unsigned T3_CYC   = 8100,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_ni,
  input  logic             hrst_i,
  input  logic             card_det_i,
  input  logic             sup_fault_i,
  input  logic             vcc_ok_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             vcc_en_o,
  output logic             io_rx_o,
  output logic             card_clk_o,
  output logic             card_rst_o,
  output logic             fault_no
);
  logic lock_done, active, clk_run_d, fault;

  sc_lockout #(.LOCK_CYC(LOCK_CYC)) i_lockout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (lock_done)
  );

  sc_seq_fsm #(.T1_CYC(T1_CYC), .T2_CYC(T2_CYC), .T3_CYC(T3_CYC)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_done_i (lock_done),
    .cmd_ni      (cmd_ni),
    .hrst_i      (hrst_i),
    .card_det_i  (card_det_i),
    .sup_fault_i (sup_fault_i),
    .vcc_ok_i    (vcc_ok_i),
    .vcc_en_o    (vcc_en_o),
    .io_rx_o     (io_rx_o),
    .active_o    (active),
    .clk_run_d_o (clk_run_d),
    .fault_o     (fault)
  );

  sc_clk_div #(.SEL_W(SEL_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (clk_run_d),
    .sel_i  (div_sel_i),
    .clk_o  (card_clk_o)
  );

  assign card_rst_o = active & hrst_i;
  assign fault_no   = ~fault;
endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk #(
  parameter int unsigned LOCK_CYC = 270000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ni,
  input logic hrst_i,
  input logic card_det_i,
  input logic sup_fault_i,
  input logic vcc_en_o,
  input logic io_rx_o,
  input logic card_clk_o,
  input logic card_rst_o,
  input logic fault_no
);
  int unsigned since_rst;
  logic [4:0]  hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      hi_len    <= '0;
    end else begin
      if (since_rst < LOCK_CYC) since_rst <= since_rst + 1;
      hi_len <= card_clk_o ? ((hi_len == 5'd31) ? hi_len : hi_len + 5'd1) : 5'd0;
    end
  end

  assert_no_start_locked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_en_o) |-> since_rst >= LOCK_CYC);

  assert_start_on_low_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_en_o) |-> !$past(cmd_ni));

  assert_start_preconds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_en_o) |-> ($past(card_det_i) && !$past(sup_fault_i) && !$past(hrst_i)));

  assert_fault_kills_vcc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_no) |-> !vcc_en_o);

  assert_io_under_vcc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rx_o |-> vcc_en_o);

  assert_clk_under_io_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_clk_o |-> io_rx_o);

  assert_rst_follows_host_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> (io_rx_o && hrst_i));

  assert_high_phase_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(card_clk_o) && io_rx_o) |-> ($countones(hi_len) == 1 && hi_len <= 5'd8));
endmodule

bind sc_act_seq sc_act_seq_chk #(.LOCK_CYC(LOCK_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ni      (cmd_ni),
  .hrst_i      (hrst_i),
  .card_det_i  (card_det_i),
  .sup_fault_i (sup_fault_i),
  .vcc_en_o    (vcc_en_o),
  .io_rx_o     (io_rx_o),
  .card_clk_o  (card_clk_o),
  .card_rst_o  (card_rst_o),
  .fault_no    (fault_no)
);

// File: tb/test_sc_act_seq.sv
module test_sc_act_seq;
  localparam int LOCK = 40;
  localparam int T1   = 6;
  localparam int T2   = 10;
  localparam int T3   = 14;

  logic clk = 1'b0;
  logic rst_ni, cmd_ni, hrst_i, card_det_i, sup_fault_i, vcc_ok_i;
  logic [1:0] div_sel_i;
  logic vcc_en_o, io_rx_o, card_clk_o, card_rst_o, fault_no;

  always #5 clk = ~clk;

  sc_act_seq #(.LOCK_CYC(LOCK), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3)) i_sc_act_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_ni(cmd_ni), .hrst_i(hrst_i),
    .card_det_i(card_det_i), .sup_fault_i(sup_fault_i), .vcc_ok_i(vcc_ok_i),
    .div_sel_i(div_sel_i), .vcc_en_o(vcc_en_o), .io_rx_o(io_rx_o),
    .card_clk_o(card_clk_o), .card_rst_o(card_rst_o), .fault_no(fault_no)
  );

  typedef struct {int at; logic [3:0] v; string tag;} exp_t;
  exp_t sbq[$];
  exp_t e;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: {vcc_en, io_rx, card_rst, fault_n}
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      e = sbq.pop_front();
      n_chk++;
      if (e.at != cyc || {vcc_en_o, io_rx_o, card_rst_o, fault_no} !== e.v) begin
        n_fail++;
        $display("FAIL %s cyc %0d: got %b expected %b (due %0d)", e.tag, cyc,
                 {vcc_en_o, io_rx_o, card_rst_o, fault_no}, e.v, e.at);
      end
    end
  end

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic push(input int at, input logic [3:0] v, input string tag);
    exp_t x;
    x.at = at; x.v = v; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic idle_for(input int from, input int n, input logic f, input string tag);
    for (int i = 0; i < n; i++) push(from + i, {3'b000, f}, tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic drain();
    while (sbq.size() > 0) drv();
    drv();
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) drv();
  endtask

  task automatic next_rise(output int c);
    logic prev;
    prev = card_clk_o;
    forever begin
      drv();
      if (!prev && card_clk_o) begin
        c = cyc;
        return;
      end
      prev = card_clk_o;
    end
  endtask

  task automatic high_len(output int n);
    n = 1;
    drv();
    while (card_clk_o) begin
      n++;
      drv();
    end
  endtask

  task automatic refuse(input logic cd, input logic hr, input logic sf);
    card_det_i = cd; hrst_i = hr; sup_fault_i = sf;
    drv();
    cmd_ni = 1'b0;
    idle_for(cyc + 1, 6, 1'b1, "R3");
    repeat (3) drv();
    cmd_ni = 1'b1; card_det_i = 1'b1; hrst_i = 1'b0; sup_fault_i = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, r1, r2, hl;
    rst_ni = 1'b0; cmd_ni = 1'b1; hrst_i = 1'b0; card_det_i = 1'b1;
    sup_fault_i = 1'b0; vcc_ok_i = 1'b0; div_sel_i = 2'd0;
    repeat (3) drv();
    push(cyc, 4'b0001, "R10");
    check(card_clk_o == 1'b0, "R10 clk in reset", card_clk_o, 0);
    rst_ni = 1'b1;
    push(cyc, 4'b0001, "R10");
    drain();

    // R1: edge inside lockout is ignored
    cmd_ni = 1'b0;
    idle_for(cyc + 1, 8, 1'b1, "R1");
    repeat (3) drv();
    cmd_ni = 1'b1;
    drain();
    repeat (LOCK) drv();
    // R2: no edge, no start after lockout
    idle_for(cyc + 1, 5, 1'b1, "R2");
    drain();

    // R3: each missing precondition blocks a start
    refuse(1'b0, 1'b0, 1'b0);
    refuse(1'b1, 1'b1, 1'b0);
    refuse(1'b1, 1'b0, 1'b1);

    // R4: supply not valid at t1
    vcc_ok_i = 1'b0;
    drv();
    cmd_ni = 1'b0; c0 = cyc + 1;
    push(c0, 4'b1001, "R4");
    push(c0 + T1 - 1, 4'b1001, "R4");
    push(c0 + T1, 4'b0000, "R4");
    push(c0 + T1 + 2, 4'b0000, "R4");
    wait_cyc(c0 + T1 + 1);
    vcc_ok_i = 1'b1;   // strobe still low: R2 no restart
    idle_for(cyc + 1, 6, 1'b0, "R2");
    drain();
    cmd_ni = 1'b1;
    drv();

    // R5: full activation, ratio 1
    div_sel_i = 2'd0;
    drv();
    cmd_ni = 1'b0; c0 = cyc + 1;
    push(c0, 4'b1001, "R9");
    push(c0 + T2 - 1, 4'b1001, "R5");
    push(c0 + T2, 4'b1101, "R5");
    push(c0 + T3 - 1, 4'b1101, "R5");
    wait_cyc(c0 + T3 - 1);
    check(card_clk_o == 1'b0, "R5 clk before t3", card_clk_o, 0);
    drv();
    check(card_clk_o == 1'b1, "R5 clk at t3", card_clk_o, 1);
    drain();

    // R6: card reset follows host reset
    hrst_i = 1'b1;
    push(cyc, 4'b1111, "R6");
    drv();
    hrst_i = 1'b0;
    push(cyc, 4'b1101, "R6");
    drain();

    // R7: period per select code
    for (int s = 0; s < 4; s++) begin
      div_sel_i = 2'(s);
      next_rise(r1); next_rise(r1); next_rise(r2);
      check((r2 - r1) == (2 << s), "R7 period", r2 - r1, 2 << s);
    end

    // R8: switch 8 -> 1 in the middle of a high phase
    div_sel_i = 2'd3;
    next_rise(r1); next_rise(r1);
    div_sel_i = 2'd0;
    high_len(hl);
    check(hl == 8, "R8 running phase keeps old ratio", hl, 8);
    next_rise(r1);
    high_len(hl);
    check(hl == 1, "R8 next phase uses new ratio", hl, 1);

    // R9: card removal while active, strobe held low
    drv();
    card_det_i = 1'b0;
    push(cyc + 1, 4'b0000, "R9");
    drv();
    check(card_clk_o == 1'b0, "R9 clk off on removal", card_clk_o, 0);
    card_det_i = 1'b1;
    idle_for(cyc + 1, 6, 1'b0, "R9");
    drain();
    cmd_ni = 1'b1;
    drv();

    // R9: supply fault mid-sequence
    drv();
    cmd_ni = 1'b0; c0 = cyc + 1;
    push(c0, 4'b1001, "R9");
    wait_cyc(c0 + T2 + 1);
    sup_fault_i = 1'b1;
    push(cyc + 1, 4'b0000, "R9");
    drain();
    sup_fault_i = 1'b0;
    cmd_ni = 1'b1;
    drain();

    done = 1;
    summary();
    $finish;
  end
endmodule